// File: doc/BRIEF.md
# Prescaled Fixed-Interval Pulse Generator

This block sits beside a compensated time counter and turns its nominal tick strobe into periodic timing outputs. It divides the tick rate by a programmable integer to make a slow output clock. It also runs two independent interval generators, and each one emits a pulse exactly one output clock period wide at a fixed spacing. One generator is normally set for one pulse per second. The other is free for any other rate. Every pulse start also raises a sticky event flag that an interrupt controller can watch. Software clears the flag by writing a one to it.

Intervals are given in nanoseconds. Each tick subtracts the tick period from a running count, and a generator fires on the tick where the remainder has dropped below one tick period. A spacing of N ticks therefore needs an interval value of (N-1) × tick period. When N is the prescaler multiplied by a divider, the pulse rate is the output clock rate divided by that divider. For example, a 10 ns tick, a prescaler of 100 and an interval of 99,990 give a 10 kHz pulse train with 1 µs pulses. An interval of 999,999,990 gives one pulse per second.

Each interval generator is a countdown FSM with the states CD_IDLE and CD_RUN. A write of a nonzero interval takes it from CD_IDLE to CD_RUN, and a write of zero returns it to CD_IDLE. Each generator also has a pulse FSM with the states PS_QUIET and PS_ACTIVE. An expiry moves it from PS_QUIET to PS_ACTIVE. On the final tick of a pulse it returns to PS_QUIET. If an expiry lands on that same final tick, it stays in PS_ACTIVE and a new pulse starts.

Top module: `interval_pulse_gen`

## Requirements
- R1: While reset is asserted, every pulse output and every event flag is 0, and the output clock is 1.
- R2: The output clock changes only on ticks. Its period is D ticks, where D is the prescale input, or 1 when prescale is 0. It is high for the first ceil(D/2) ticks of each period and low for the rest.
- R3: While running, each tick lowers a generator's count by the tick period. On the tick where the count is below the tick period, the generator fires and reloads its count from its interval register. An interval of (N-1) × tick period therefore gives one expiry every N ticks. With a 10 ns tick and an interval of 99,990, that is every 10,000 ticks.
- R4: A pulse output rises in the cycle after the tick that starts the pulse. It stays high for exactly D ticks and falls in the cycle after the D-th following tick.
- R5: An interval write loads both the interval register and the count in that cycle, and a tick in the same cycle is not applied to the count. With a tick every cycle, an interval of V written at edge w gives a pulse rise V+1 cycles later. A pulse already in progress keeps its full width.
- R6: An expiry during a pulse, other than on its final tick, starts nothing. An expiry on the final tick starts a new pulse at once, so the output stays high.
- R7: A generator whose interval register holds 0 never fires. This includes the state after reset.
- R8: Bit g of the event output is set in the cycle a pulse of generator g starts, and it stays set until a 1 on clear bit g. When a start and a clear fall in the same cycle, the flag is left set.
- R9: The generators share only the tick, the tick period and the prescale value. A write, a clear or a pulse on one generator does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Nominal tick strobe from the time counter |
| tick_period | input | PERIOD_W | Tick period in ns |
| prescale | input | PRESC_W | Output clock divider, with 0 treated as 1 |
| ivl_wr | input | NGEN | Per-generator interval write strobe |
| ivl_data | input | IVL_W | Interval value to write, in ns |
| evt_clr | input | NGEN | Write-one-to-clear for the event flags |
| oclk | output | 1 | Prescaled output clock |
| pulse | output | NGEN | Periodic pulse outputs |
| evt | output | NGEN | Sticky event flags |

## Verification
The bench measures the spacing of pulse rises and pulse widths in two cases: the 10 kHz example alongside a second, faster generator, and short intervals where an expiry lands inside a pulse. An off-by-one countdown would shift the spacing by one tick. A pulse FSM that retriggered on every expiry would stretch the pulse, and one that ignored an expiry on the final tick would drop every other pulse. Directed cases cover a write in the middle of a pulse, which a design that truncated or re-timed the pulse would get wrong. They also cover a clear that arrives together with a start, which a clear-priority flag would lose. A random run changes the tick pattern, the tick period, the prescaler, writes that include zero, and clears, all checked cycle by cycle against a bench model.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    // Countdown FSM: idle while the interval register is zero
    typedef enum logic {
        CD_IDLE,
        CD_RUN
    } cd_state_e;

    // Pulse FSM: output low or high
    typedef enum logic {
        PS_QUIET,
        PS_ACTIVE
    } ps_state_e;

endpackage

// File: rtl/fpg_prescaler.sv
module fpg_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [PRESC_W-1:0] prescale,
    output logic [PRESC_W-1:0] presc_eff,
    output logic               oclk
);
    localparam int CW = PRESC_W + 1;

    logic [PRESC_W-1:0] phase;
    logic [CW-1:0]      div;
    logic [CW-1:0]      half;
    logic [CW-1:0]      phase_inc;

    always_comb begin
        div       = (prescale == '0) ? CW'(1) : {1'b0, prescale};
        half      = (div + CW'(1)) >> 1;
        phase_inc = {1'b0, phase} + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            // wrap also covers a prescale that shrank below the phase
            phase <= (phase_inc >= div) ? '0 : phase_inc[PRESC_W-1:0];
        end
    end

    assign presc_eff = div[PRESC_W-1:0];
    assign oclk      = ({1'b0, phase} < half);

endmodule

// File: rtl/fpg_countdown.sv
module fpg_countdown #(
    parameter int IVL_W    = 32,
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] tick_period,
    input  logic                wr,
    input  logic [IVL_W-1:0]    wdata,
    output logic                expire
);
    import fpg_pkg::*;

    cd_state_e        state;
    cd_state_e        state_nxt;
    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] remain;
    logic [IVL_W-1:0] step;
    logic             below_step;

    assign step = IVL_W'(tick_period);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CD_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            CD_IDLE: if (wr && (wdata != '0)) state_nxt = CD_RUN;
            CD_RUN:  if (wr && (wdata == '0)) state_nxt = CD_IDLE;
            default: state_nxt = CD_IDLE;
        endcase
    end

    // interval register and running count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q  <= '0;
            remain <= '0;
        end else if (wr) begin
            ivl_q  <= wdata;
            remain <= wdata;
        end else if ((state == CD_RUN) && tick) begin
            remain <= below_step ? ivl_q : (remain - step);
        end
    end

    // outputs
    always_comb begin
        below_step = (remain < step);
        expire     = (state == CD_RUN) && tick && !wr && below_step;
    end

endmodule

// File: rtl/fpg_pulse_fsm.sv
module fpg_pulse_fsm #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               expire,
    input  logic [PRESC_W-1:0] presc_eff,
    output logic               pulse,
    output logic               start
);
    import fpg_pkg::*;

    ps_state_e          state;
    ps_state_e          state_nxt;
    logic [PRESC_W-1:0] width_left;
    logic               last_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_QUIET;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        last_tick = tick && (width_left <= PRESC_W'(1));
        state_nxt = state;
        unique case (state)
            PS_QUIET:  if (expire)                 state_nxt = PS_ACTIVE;
            PS_ACTIVE: if (last_tick && !expire)   state_nxt = PS_QUIET;
            default:                               state_nxt = PS_QUIET;
        endcase
    end

    // width counter in ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_left <= '0;
        end else if (start) begin
            width_left <= presc_eff;
        end else if ((state == PS_ACTIVE) && tick) begin
            width_left <= width_left - PRESC_W'(1);
        end
    end

    // outputs
    always_comb begin
        pulse = (state == PS_ACTIVE);
        unique case (state)
            PS_QUIET:  start = expire;
            PS_ACTIVE: start = last_tick && expire;
            default:   start = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpg_event_flag.sv
module fpg_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !clr) || set;
    end
endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen #(
    parameter int NGEN     = 2,
    parameter int IVL_W    = 32,
    parameter int PERIOD_W = 8,
    parameter int PRESC_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] tick_period,
    input  logic [PRESC_W-1:0]  prescale,
    input  logic [NGEN-1:0]     ivl_wr,
    input  logic [IVL_W-1:0]    ivl_data,
    input  logic [NGEN-1:0]     evt_clr,
    output logic                oclk,
    output logic [NGEN-1:0]     pulse,
    output logic [NGEN-1:0]     evt
);
    logic [PRESC_W-1:0] presc_eff;

    fpg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .prescale  (prescale),
        .presc_eff (presc_eff),
        .oclk      (oclk)
    );

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic expire;
        logic start;

        fpg_countdown #(.IVL_W(IVL_W), .PERIOD_W(PERIOD_W)) u_cd (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick),
            .tick_period (tick_period),
            .wr          (ivl_wr[g]),
            .wdata       (ivl_data),
            .expire      (expire)
        );

        fpg_pulse_fsm #(.PRESC_W(PRESC_W)) u_pfsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .expire    (expire),
            .presc_eff (presc_eff),
            .pulse     (pulse[g]),
            .start     (start)
        );

        fpg_event_flag u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (start),
            .clr   (evt_clr[g]),
            .flag  (evt[g])
        );
    end

endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
    parameter int NGEN    = 2,
    parameter int PRESC_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [PRESC_W-1:0] prescale,
    input logic [NGEN-1:0]    evt_clr,
    input logic               oclk,
    input logic [NGEN-1:0]    pulse,
    input logic [NGEN-1:0]    evt
);
    // R2: output clock moves only on a tick (or a prescale change)
    p_oclk_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(oclk) || !$stable(prescale)));

    for (genvar g = 0; g < NGEN; g++) begin : g_chk
        // R3: without a tick a pulse output cannot change
        p_quiet_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(pulse[g]));

        // R4: pulse edges follow a tick
        p_rise_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse[g]) |-> $past(tick));
        p_fall_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pulse[g]) |-> $past(tick));

        // R8: a pulse start flags the event; flag only rises with a pulse
        p_start_flags_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse[g]) |-> evt[g]);
        p_event_rise_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt[g]) |-> pulse[g]);
        p_event_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && !evt_clr[g]) |=> evt[g]);
    end
endmodule

bind interval_pulse_gen fpg_checker #(.NGEN(NGEN), .PRESC_W(PRESC_W)) u_fpg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .prescale (prescale),
    .evt_clr  (evt_clr),
    .oclk     (oclk),
    .pulse    (pulse),
    .evt      (evt)
);

// File: tb/tb_interval_pulse_gen.sv
module tb_interval_pulse_gen;
    localparam int NG = 2;
    localparam int PW = 8;
    localparam int SW = 16;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [PW-1:0] tp = 8'd1;
    logic [SW-1:0] presc = 16'd4;
    logic [NG-1:0] wr = '0;
    logic [NG-1:0] clr = '0;
    logic [IW-1:0] wdata = '0;
    logic          oclk;
    logic [NG-1:0] pulse;
    logic [NG-1:0] evt;

    always #4 clk = ~clk;

    interval_pulse_gen #(.NGEN(NG), .IVL_W(IW), .PERIOD_W(PW), .PRESC_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tick_period(tp), .prescale(presc),
        .ivl_wr(wr), .ivl_data(wdata), .evt_clr(clr), .oclk(oclk), .pulse(pulse), .evt(evt)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wcyc   = 0;
    bit tick_all = 1'b1;
    int tick_pct = 100;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic longint div_of(logic [SW-1:0] p);
        return (p == 0) ? 1 : longint'(p);
    endfunction

    // reference model, built from the requirements
    longint unsigned m_ivl [NG];
    longint unsigned m_cnt [NG];
    bit              m_act [NG];
    longint          m_w   [NG];
    bit              m_evt [NG];
    longint          m_ph;

    always @(posedge clk) begin : mdl
        longint pe;
        bit fire;
        bit strt;
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_ivl[g] = 0; m_cnt[g] = 0; m_act[g] = 0; m_w[g] = 0; m_evt[g] = 0;
            end
            m_ph = 0;
        end else begin
            pe = div_of(presc);
            for (int g = 0; g < NG; g++) begin
                fire = !wr[g] && tick && (m_ivl[g] != 0) && (m_cnt[g] < tp);
                if (wr[g]) begin
                    m_ivl[g] = wdata; m_cnt[g] = wdata;
                end else if (tick && m_ivl[g] != 0) begin
                    m_cnt[g] = fire ? m_ivl[g] : m_cnt[g] - tp;
                end
                strt = 0;
                if (!m_act[g]) begin
                    if (fire) begin m_act[g] = 1; m_w[g] = pe; strt = 1; end
                end else if (tick) begin
                    if (m_w[g] <= 1) begin
                        if (fire) begin m_w[g] = pe; strt = 1; end
                        else m_act[g] = 0;
                    end else m_w[g] = m_w[g] - 1;
                end
                m_evt[g] = (m_evt[g] && !clr[g]) || strt;
            end
            if (tick) m_ph = (m_ph + 1 >= pe) ? 0 : m_ph + 1;
        end
    end

    // sampler: model comparison and edge monitor
    bit prevp [NG];
    int rise_last [NG];
    int rise_prev [NG];
    int width_last [NG];
    int nrise [NG];
    int nfall [NG];

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            cyc++;
            chk("R2", "oclk vs model", oclk, (m_ph < (div_of(presc) + 1) / 2) ? 1 : 0);
            for (int g = 0; g < NG; g++) begin
                chk("R4", "pulse vs model", pulse[g], m_act[g]);
                chk("R8", "event vs model", evt[g], m_evt[g]);
                if (pulse[g] && !prevp[g]) begin
                    rise_prev[g] = rise_last[g]; rise_last[g] = cyc; nrise[g]++;
                end
                if (!pulse[g] && prevp[g]) begin
                    width_last[g] = cyc - rise_last[g]; nfall[g]++;
                end
                prevp[g] = pulse[g];
            end
        end
    end

    always @(negedge clk) begin
        if (tick_all) tick = 1'b1;
        else          tick = ($urandom_range(99) < tick_pct);
    end

    task automatic wr_ivl(int g, longint v);
        @(negedge clk);
        wr[g] = 1'b1; wdata = IW'(v);
        @(negedge clk);
        wr[g] = 1'b0;
        wcyc = cyc;
    endtask

    task automatic wait_rises(int g, int n, int limit);
        int target;
        target = nrise[g] + n;
        for (int i = 0; i < limit && nrise[g] < target; i++) @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int r;
        int f1;
        void'($urandom(32'd7741));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "pulse in reset", pulse, 0);
        chk("R1", "event in reset", evt, 0);
        chk("R1", "oclk in reset", oclk, 1);
        rst_n = 1'b1;

        // R7: interval zero after reset and after an explicit write of zero
        repeat (40) @(negedge clk);
        wr_ivl(1, 0);
        repeat (40) @(negedge clk);
        chk("R7", "rises with zero interval g0", nrise[0], 0);
        chk("R7", "rises with zero interval g1", nrise[1], 0);
        chk("R7", "events with zero interval", evt, 0);

        // R3/R4/R9: 10 kHz example next to a 300-tick generator
        tp = 8'd10; presc = 16'd100;
        wr_ivl(0, 99990);
        wr_ivl(1, 2990);
        wait_rises(0, 3, 40000);
        chk("R3", "g0 spacing in ticks", rise_last[0] - rise_prev[0], 10000);
        chk("R4", "g0 width in ticks", width_last[0], 100);
        chk("R9", "g1 spacing beside g0", rise_last[1] - rise_prev[1], 300);
        chk("R9", "g1 width beside g0", width_last[1], 100);

        // R5: write during a pulse
        tp = 8'd1; presc = 16'd8;
        wr_ivl(1, 0);
        wr_ivl(0, 99);
        repeat (120) @(negedge clk);
        wait_rises(0, 1, 300);
        f1 = nrise[1];
        repeat (2) @(negedge clk);
        wr_ivl(0, 29);
        wait_rises(0, 1, 300);
        chk("R5", "pulse width across write", width_last[0], 8);
        chk("R5", "first rise after write", rise_last[0] - wcyc, 30);
        chk("R9", "g1 untouched by g0 write", nrise[1], f1);

        // R6: expiries inside a pulse
        presc = 16'd10;
        wr_ivl(0, 3);
        wr_ivl(1, 4);
        wait_rises(0, 3, 500);
        chk("R6", "g0 spacing with mid-pulse expiries", rise_last[0] - rise_prev[0], 12);
        chk("R6", "g0 width with mid-pulse expiries", width_last[0], 10);
        f1 = nfall[1];
        repeat (40) @(negedge clk);
        chk("R6", "g1 falls with retrigger on final tick", nfall[1], f1);
        chk("R6", "g1 held high", pulse[1], 1);

        // R8: clear colliding with a start, then a plain clear
        wait_rises(0, 1, 100);
        r = rise_last[0];
        while (cyc < r + 11) @(negedge clk);
        clr[0] = 1'b1;
        @(negedge clk);
        clr[0] = 1'b0;
        chk("R8", "set beats clear", evt[0], 1);
        clr[0] = 1'b1;
        @(negedge clk);
        clr[0] = 1'b0;
        chk("R8", "clear without start", evt[0], 0);
        chk("R9", "g1 flag kept on g0 clear", evt[1], 1);

        // random phase, checked against the model every cycle
        tick_all = 1'b0;
        tick_pct = 70;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ($urandom_range(199) == 0) presc = SW'($urandom_range(6));
            if ($urandom_range(199) == 0) tp = PW'($urandom_range(4, 1));
            if ($urandom_range(9) == 0) tick_pct = $urandom_range(100, 20);
            for (int g = 0; g < NG; g++) begin
                wr[g]  = ($urandom_range(299) == 0);
                clr[g] = ($urandom_range(19) == 0);
            end
            wdata = IW'($urandom_range(40));
        end
        @(negedge clk);
        wr = '0; clr = '0;
        repeat (5) @(negedge clk);
        report();
        $finish;
    end
endmodule